// File: doc/BRIEF.md
# Interrupt Mask and Status Controller

This block gathers thirty interrupt sources of a network controller into one level-sensitive interrupt line. Each source delivers a one-cycle event pulse, which is latched into a pending-flag register whatever the mask says. A mask register decides which pending flags may drive the interrupt line. Software reads the pending flags through a small memory-mapped register bus, and that read clears them.

The mask cannot be written directly. Two write-only registers change it. One opens sources by clearing mask bits. The other shuts sources by setting mask bits. A write to the mask's own address leaves the mask alone. It loads the pending flags from the write data instead, so firmware can raise or drop any interrupt on purpose when testing. Register reads are combinational on the bus cycle. All state changes at the clock edge that ends that cycle.

The bus side is a decoder with two enumerated access kinds. The write kinds are WR_NONE, WR_TEST, WR_OPEN and WR_SHUT. The read kinds are RD_NONE, RD_FLAGS, RD_GATE and RD_ZERO. Each bus cycle selects exactly one write kind and one read kind, and that kind only lasts for that cycle. There are no held states, so there are no transitions between states.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask reads 0x3FFFFFFF (all thirty sources shut), the pending flags read 0, and the interrupt line is low.
- R2: The register offsets are: pending flags at 0x024, open at 0x028, shut at 0x02C, mask at 0x030. Bits 31 and 30 of every register read as 0 and ignore writes. The open and shut offsets, and any unmapped offset, read as 0.
- R3: Writing the open register clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Writing the shut register sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R5: A write to the mask offset leaves the mask unchanged. It loads pending flags [29:0] from the write data, so 1 sets a flag and 0 clears it, regardless of the mask.
- R6: The interrupt line is a register. At each edge it takes the OR over all bits of (pending AND NOT mask), using the values held before that edge. It therefore follows a flag or mask change by one cycle.
- R7: Event input bit i sets pending flag i whatever the mask. Bit 0 is frame receive, 1 receive complete, 7 transmit complete, 10 receive overrun, 28 wake-on-LAN and 29 timer compare. Opening a source whose flag is already set raises the interrupt one cycle after the open write.
- R8: A read of the pending-flag offset returns the flags held before the edge, then clears them at that edge.
- R9: An event pulse in the same cycle as a clearing read, or as a test write of 0, wins: that flag is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| evt_pulse | input | 30 | Per-source event pulses |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situations to set up are the collisions in which an event pulse lands in the same cycle as a clearing read, or as a test write that clears the flag. Both can only be reached by aligning a bus strobe and a pulse on one exact edge. Directed steps force both collisions on chosen bits. Seeded random traffic then mixes sparse pulses with every bus operation, so the same collisions also occur on random bits while the mask is in random states.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned SRC_N  = 30;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_FLAGS = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_OPEN  = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_SHUT  = 12'h02C;
    localparam logic [ADDR_W-1:0] OFS_GATE  = 12'h030;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_TEST,
        WR_OPEN,
        WR_SHUT
    } wr_kind_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_FLAGS,
        RD_GATE,
        RD_ZERO
    } rd_kind_e;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irq_mask_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output wr_kind_e      wr_kind,
    output rd_kind_e      rd_kind
);
    always_comb begin
        wr_kind = WR_NONE;
        if (wr) begin
            unique case (addr)
                OFS_GATE: wr_kind = WR_TEST;
                OFS_OPEN: wr_kind = WR_OPEN;
                OFS_SHUT: wr_kind = WR_SHUT;
                default:  wr_kind = WR_NONE;
            endcase
        end
    end

    always_comb begin
        rd_kind = RD_NONE;
        if (rd) begin
            unique case (addr)
                OFS_FLAGS: rd_kind = RD_FLAGS;
                OFS_GATE:  rd_kind = RD_GATE;
                default:   rd_kind = RD_ZERO;
            endcase
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned N = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_ld,
    input  logic [N-1:0] test_val,
    input  logic         rd_clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags
);
    logic [N-1:0] base;

    always_comb begin
        if (test_ld)      base = test_val;
        else if (rd_clr)  base = '0;
        else              base = flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= base | evt;
    end

    // R7 / R9: every pulsed source is pending after the edge
    p_evt_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    // R8: a clearing read with no pulse and no test load empties the bank
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !test_ld && evt == '0) |=> (flags == '0));

    // R5: test load with no pulse copies the data exactly
    p_test_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_ld && evt == '0) |=> (flags == $past(test_val)));
endmodule

// File: rtl/irq_gate_bank.sv
module irq_gate_bank #(
    parameter int unsigned N = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_wr,
    input  logic         shut_wr,
    input  logic [N-1:0] bits,
    output logic [N-1:0] gate
);
    always_ff @(posedge clk) begin
        if (!rst_n)       gate <= '1;
        else if (open_wr) gate <= gate & ~bits;
        else if (shut_wr) gate <= gate | bits;
    end

    // R3: opened bits read back as 0
    p_open_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        open_wr |=> ((gate & $past(bits)) == '0));

    // R4: shut bits read back as 1
    p_shut_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shut_wr |=> ((gate & $past(bits)) == $past(bits)));

    // R5: without an open or shut write the mask holds
    p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_wr && !shut_wr) |=> $stable(gate));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int unsigned SRC_CNT = SRC_N,
    parameter int unsigned DW      = REG_W,
    parameter int unsigned AW      = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_rd,
    output logic [DW-1:0]      bus_rdata,
    input  logic [SRC_CNT-1:0] evt_pulse,
    output logic               irq_o
);
    localparam int unsigned PAD_W = DW - SRC_CNT;

    wr_kind_e           wr_kind;
    rd_kind_e           rd_kind;
    logic [SRC_CNT-1:0] flags;
    logic [SRC_CNT-1:0] gate;
    logic [SRC_CNT-1:0] rd_val;
    logic               irq_q;

    irq_decode #(.AW(AW)) u_decode (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wr_kind (wr_kind),
        .rd_kind (rd_kind)
    );

    irq_flag_bank #(.N(SRC_CNT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_ld  (wr_kind == WR_TEST),
        .test_val (bus_wdata[SRC_CNT-1:0]),
        .rd_clr   (rd_kind == RD_FLAGS),
        .evt      (evt_pulse),
        .flags    (flags)
    );

    irq_gate_bank #(.N(SRC_CNT)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_wr (wr_kind == WR_OPEN),
        .shut_wr (wr_kind == WR_SHUT),
        .bits    (bus_wdata[SRC_CNT-1:0]),
        .gate    (gate)
    );

    always_comb begin
        unique case (rd_kind)
            RD_FLAGS: rd_val = flags;
            RD_GATE:  rd_val = gate;
            RD_ZERO:  rd_val = '0;
            default:  rd_val = '0;
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign bus_rdata = {{PAD_W{1'b0}}, rd_val};
        end else begin : g_nopad
            assign bus_rdata = rd_val;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags & ~gate);
    end
    assign irq_o = irq_q;

    // R6: a raised line needs a pending flag one cycle earlier
    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(flags != '0));

    // R6: a fully shut mask keeps the line low
    p_irq_all_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&gate) |-> !irq_o);

    // R2: upper bits of read data stay zero
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata >> SRC_CNT) == '0);
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
    localparam int N = 30;
    localparam logic [11:0] A_FLG = 12'h024, A_OPN = 12'h028,
                            A_SHT = 12'h02C, A_GAT = 12'h030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] evt_pulse = '0;
    logic        irq_o;

    int n_chk = 0, n_fail = 0;
    logic [N-1:0] m_flg, m_gat;
    logic         m_irq;
    bit           done = 0;

    always #2 clk = ~clk;

    irq_mask_ctrl i_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq_o(irq_o)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == A_FLG) return {2'b00, m_flg};
        if (a == A_GAT) return {2'b00, m_gat};
        return 32'h0;
    endfunction

    function automatic string read_req(input logic [11:0] a);
        if (a == A_FLG) return "R8";
        if (a == A_GAT) return "R3/R4 mask read";
        return "R2";
    endfunction

    // one bus cycle: drive after falling edge, check reads, model the edge, check line
    task automatic step(input logic wr, input logic rd, input logic [11:0] a,
                        input logic [31:0] d, input logic [N-1:0] e);
        logic [N-1:0] base;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_pulse = e;
        #1;
        if (rd) check(bus_rdata, exp_read(a), read_req(a));
        @(posedge clk);
        m_irq = |(m_flg & ~m_gat);
        if (wr && a == A_GAT)      base = d[N-1:0];
        else if (rd && a == A_FLG) base = '0;
        else                       base = m_flg;
        m_flg = base | e;
        if (wr && a == A_OPN) m_gat = m_gat & ~d[N-1:0];
        if (wr && a == A_SHT) m_gat = m_gat | d[N-1:0];
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; evt_pulse = '0;
        check({31'b0, irq_o}, {31'b0, m_irq}, "R6");
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_flg = '0; m_gat = '1; m_irq = 0;
        // R1 reset state
        check({31'b0, irq_o}, 32'h0, "R1 irq");
        step(0, 1, A_GAT, 0, '0);
        check(32'h3FFF_FFFF, {2'b0, m_gat}, "R1 mask model");
        step(0, 1, A_FLG, 0, '0);
        // R2 unmapped and write-only offsets read 0
        step(0, 1, A_OPN, 0, '0);
        step(0, 1, A_SHT, 0, '0);
        step(0, 1, 12'h100, 0, '0);
        // R5 test write with all ones, bits 30/31 dropped, mask untouched
        step(1, 0, A_GAT, 32'hFFFF_FFFF, '0);
        step(0, 1, A_FLG, 0, '0);
        step(0, 1, A_GAT, 0, '0);
        // R7 events latch while shut, then opening raises the line
        step(0, 0, 0, 0, 30'h2000_0001);   // bit 29 timer compare, bit 0 frame receive
        step(1, 0, A_OPN, 32'h2000_0000, '0);
        step(0, 0, 0, 0, '0);
        check({31'b0, irq_o}, 32'h1, "R7 open pending");
        // R4 shut it again, line drops
        step(1, 0, A_SHT, 32'hFFFF_FFFF, '0);
        step(0, 0, 0, 0, '0);
        check({31'b0, irq_o}, 32'h0, "R4 shut drop");
        // R9 collision: clearing read with pulse on bit 10
        step(0, 1, A_FLG, 0, 30'h0000_0400);
        step(0, 1, A_FLG, 0, '0);
        // R9 collision: test write of 0 with pulse on bit 28 wake
        step(1, 0, A_GAT, 32'h0, 30'h1000_0000);
        step(0, 1, A_FLG, 0, '0);
        // R3 partial open keeps other bits
        step(1, 0, A_OPN, 32'h0000_0081, '0);
        step(0, 1, A_GAT, 0, '0);
        // random traffic
        for (int i = 0; i < 1500; i++) begin
            int op = $urandom_range(0, 6);
            logic [31:0] d = $urandom();
            logic [N-1:0] e = ($urandom_range(0, 3) == 0) ? (N'(1) << $urandom_range(0, N-1)) : '0;
            case (op)
                0: step(1, 0, A_OPN, d & $urandom(), e);
                1: step(1, 0, A_SHT, d & $urandom(), e);
                2: step(1, 0, A_GAT, d & $urandom() & $urandom(), e);
                3: step(0, 1, A_FLG, 0, e);
                4: step(0, 1, A_GAT, 0, e);
                5: step(0, 1, (op[0] ? A_OPN : A_SHT), 0, e);
                default: step(0, 0, 0, 0, e);
            endcase
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule